// File: doc/BRIEF.md
# Interleaved Stream Channel Selector

This block sits on a byte stream between a producer and a consumer. The incoming stream holds several images woven together in fixed-size chunks. One chunk belongs to image 1, the next to image 2, and so on until the sequence wraps back to image 1. The block passes on only the bytes of one chosen image. It consumes every other byte and discards it, so the consumer sees one contiguous image.

Ownership is decided by a running count of accepted input bytes. That count restarts at zero on a restart strobe. The restart strobe is also the only moment when the channel select input is sampled. Channels are numbered from 1. A select of 0, or one above the number of images, forwards nothing and raises an error flag. In that state the input stream is still drained.

The path from input to output has no register. Forwarded bytes go straight through, and the output ready controls the input ready while the block is forwarding. The chunk length, the image count and the select width are parameters.

Top module: `ilv_stream_select`

## Requirements
- R1: After reset the block selects channel 1, the byte count is zero, sel_err is 0, and no byte is forwarded before a byte of chunk 0 arrives.
- R2: The input byte with zero-based index k since the last restart or reset belongs to the selected channel c exactly when (k / CHUNK_LEN) mod NUM_CH equals c - 1. Only such bytes raise out_valid.
- R3: While the current byte is not owned by the selected channel, in_ready is 1 whatever out_ready is, and out_valid is 0.
- R4: While the current byte is owned, out_valid equals in_valid, in_ready equals out_ready, and out_data equals in_data.
- R5: In a cycle with restart high, in_ready and out_valid are 0. On that edge the count returns to zero and chan_sel is captured.
- R6: chan_sel has no effect in any cycle without restart.
- R7: A captured select of 0 or greater than NUM_CH sets sel_err to 1 from the next cycle on. Nothing is forwarded in that state, and every input byte is accepted. A valid select clears sel_err.
- R8: After NUM_CH * CHUNK_LEN accepted bytes the ownership pattern repeats from chunk 0.
- R9: The count advances only on a cycle where in_valid and in_ready are both 1. A stalled owned byte does not move it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| restart | input | 1 | Start of a new stream: clears the count and samples chan_sel |
| chan_sel | input | SEL_W | 1-based image number to keep |
| in_valid | input | 1 | Input byte valid |
| in_data | input | DATA_W | Input byte |
| in_ready | output | 1 | Input byte accepted when high together with in_valid |
| out_valid | output | 1 | Forwarded byte valid |
| out_data | output | DATA_W | Forwarded byte |
| out_ready | input | 1 | Consumer ready |
| sel_err | output | 1 | Captured select is out of range |

## Verification
The bench runs long random streams with random valid gaps and back-pressure, so every chunk edge and the wrap after the last image are crossed several times. An off-by-one chunk counter would shift the forwarded window by a byte. A count that advanced on stalled bytes would drift away from the model and forward the wrong chunk. chan_sel is changed randomly on cycles without restart, which catches a design that tracks the select live instead of latching it. The bench also selects channel 0 and a channel above the image count. A design that wrapped the select modulo the image count would then forward data, and one that stopped draining input would drop in_ready.

// File: rtl/ilv_stream_select_pkg.sv
package ilv_stream_select_pkg;

    // Per-byte decision of the flow gate
    typedef enum logic [1:0] {
        GATE_HOLD = 2'd0,   // restart cycle: accept nothing, emit nothing
        GATE_DROP = 2'd1,   // byte belongs elsewhere: swallow it
        GATE_PASS = 2'd2    // byte belongs to the selected image
    } gate_e;

    localparam int DEF_CHUNK_LEN = 288;
    localparam int DEF_NUM_CH    = 2;

    function automatic gate_e pick_gate(input logic restart,
                                        input logic bad_sel,
                                        input logic owned);
        if (restart)
            return GATE_HOLD;
        else if (bad_sel || !owned)
            return GATE_DROP;
        else
            return GATE_PASS;
    endfunction

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/ilv_chunk_tracker.sv
module ilv_chunk_tracker #(
    parameter int CHUNK_LEN = ilv_stream_select_pkg::DEF_CHUNK_LEN,
    parameter int NUM_CH    = ilv_stream_select_pkg::DEF_NUM_CH,
    localparam int OFS_W    = ilv_stream_select_pkg::idx_width(CHUNK_LEN),
    localparam int IDX_W    = ilv_stream_select_pkg::idx_width(NUM_CH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             advance,
    output logic [OFS_W-1:0] chunk_ofs,
    output logic [IDX_W-1:0] chunk_idx
);
    localparam logic [OFS_W-1:0] LAST_OFS = OFS_W'(CHUNK_LEN - 1);

    logic ofs_wrap;
    assign ofs_wrap = (chunk_ofs == LAST_OFS);

    // Offset inside the current chunk
    always_ff @(posedge clk) begin
        if (rst || clear)
            chunk_ofs <= '0;
        else if (advance)
            chunk_ofs <= ofs_wrap ? '0 : chunk_ofs + OFS_W'(1);
    end

    // Index of the owning image, stepped at each chunk end
    generate
        if (NUM_CH > 1) begin : g_multi
            localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_CH - 1);
            always_ff @(posedge clk) begin
                if (rst || clear)
                    chunk_idx <= '0;
                else if (advance && ofs_wrap)
                    chunk_idx <= (chunk_idx == LAST_IDX) ? '0 : chunk_idx + IDX_W'(1);
            end
        end else begin : g_single
            always_ff @(posedge clk) begin
                chunk_idx <= '0;
            end
        end
    endgenerate

endmodule

// File: rtl/ilv_chan_latch.sv
module ilv_chan_latch #(
    parameter int NUM_CH = ilv_stream_select_pkg::DEF_NUM_CH,
    parameter int SEL_W  = 4,
    localparam int IDX_W = ilv_stream_select_pkg::idx_width(NUM_CH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [SEL_W-1:0] chan_sel,
    output logic [IDX_W-1:0] sel_idx,
    output logic             bad_sel
);
    localparam logic [SEL_W-1:0] MAX_SEL = SEL_W'(NUM_CH);

    logic             sel_out_of_range;
    logic [SEL_W-1:0] sel_minus_one;

    assign sel_out_of_range = (chan_sel == '0) || (chan_sel > MAX_SEL);
    assign sel_minus_one    = chan_sel - SEL_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_idx <= '0;
            bad_sel <= 1'b0;
        end else if (load) begin
            sel_idx <= IDX_W'(sel_minus_one);
            bad_sel <= sel_out_of_range;
        end
    end

endmodule

// File: rtl/ilv_flow_gate.sv
module ilv_flow_gate #(
    parameter int DATA_W = 8
) (
    input  ilv_stream_select_pkg::gate_e gate,
    input  logic                         in_valid,
    input  logic [DATA_W-1:0]            in_data,
    input  logic                         out_ready,
    output logic                         in_ready,
    output logic                         out_valid,
    output logic [DATA_W-1:0]            out_data,
    output logic                         advance
);
    import ilv_stream_select_pkg::*;

    always_comb begin
        unique case (gate)
            GATE_PASS: begin
                in_ready  = out_ready;
                out_valid = in_valid;
            end
            GATE_DROP: begin
                in_ready  = 1'b1;
                out_valid = 1'b0;
            end
            default: begin
                in_ready  = 1'b0;
                out_valid = 1'b0;
            end
        endcase
    end

    assign out_data = in_data;
    assign advance  = in_valid && in_ready;

endmodule

// File: rtl/ilv_stream_select.sv
module ilv_stream_select #(
    parameter int CHUNK_LEN = ilv_stream_select_pkg::DEF_CHUNK_LEN,
    parameter int NUM_CH    = ilv_stream_select_pkg::DEF_NUM_CH,
    parameter int SEL_W     = 4,
    parameter int DATA_W    = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic [SEL_W-1:0]  chan_sel,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    input  logic              out_ready,
    output logic              sel_err
);
    import ilv_stream_select_pkg::*;

    localparam int OFS_W = idx_width(CHUNK_LEN);
    localparam int IDX_W = idx_width(NUM_CH);

    logic [OFS_W-1:0] chunk_ofs;
    logic [IDX_W-1:0] chunk_idx;
    logic [IDX_W-1:0] sel_idx;
    logic             bad_sel;
    logic             owned;
    logic             advance;
    gate_e            gate;

    ilv_chunk_tracker #(
        .CHUNK_LEN (CHUNK_LEN),
        .NUM_CH    (NUM_CH)
    ) tracker_i (
        .clk       (clk),
        .rst       (rst),
        .clear     (restart),
        .advance   (advance),
        .chunk_ofs (chunk_ofs),
        .chunk_idx (chunk_idx)
    );

    ilv_chan_latch #(
        .NUM_CH   (NUM_CH),
        .SEL_W    (SEL_W)
    ) latch_i (
        .clk      (clk),
        .rst      (rst),
        .load     (restart),
        .chan_sel (chan_sel),
        .sel_idx  (sel_idx),
        .bad_sel  (bad_sel)
    );

    assign owned = (chunk_idx == sel_idx);
    assign gate  = pick_gate(restart, bad_sel, owned);

    ilv_flow_gate #(
        .DATA_W    (DATA_W)
    ) gate_i (
        .gate      (gate),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .advance   (advance)
    );

    assign sel_err = bad_sel;

endmodule

// File: rtl/ilv_stream_select_chk.sv
module ilv_stream_select_chk #(
    parameter int CHUNK_LEN = ilv_stream_select_pkg::DEF_CHUNK_LEN,
    parameter int NUM_CH    = ilv_stream_select_pkg::DEF_NUM_CH,
    localparam int OFS_W    = ilv_stream_select_pkg::idx_width(CHUNK_LEN),
    localparam int IDX_W    = ilv_stream_select_pkg::idx_width(NUM_CH)
) (
    input logic             clk,
    input logic             rst,
    input logic             restart,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic             sel_err,
    input logic [OFS_W-1:0] chunk_ofs,
    input logic [IDX_W-1:0] chunk_idx
);
    localparam logic [OFS_W-1:0] OFS_LIMIT = OFS_W'(CHUNK_LEN - 1);
    localparam logic [IDX_W-1:0] IDX_LIMIT = IDX_W'(NUM_CH - 1);

    // R5
    restart_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        restart |-> (!in_ready && !out_valid));

    // R5
    restart_clears_count_chk: assert property (@(posedge clk) disable iff (rst)
        restart |=> (chunk_ofs == '0 && chunk_idx == '0));

    // R7
    err_blocks_output_chk: assert property (@(posedge clk) disable iff (rst)
        sel_err |-> !out_valid);

    // R7
    err_drains_input_chk: assert property (@(posedge clk) disable iff (rst)
        (sel_err && !restart) |-> in_ready);

    // R3
    drop_always_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !out_valid && !restart) |-> in_ready);

    // R4
    pass_follows_ready_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (in_ready == out_ready));

    // R9
    stall_holds_count_chk: assert property (@(posedge clk) disable iff (rst)
        (!restart && !(in_valid && in_ready)) |=> $stable(chunk_ofs) && $stable(chunk_idx));

    // R8
    count_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        (chunk_ofs <= OFS_LIMIT) && (chunk_idx <= IDX_LIMIT));

endmodule

bind ilv_stream_select ilv_stream_select_chk #(
    .CHUNK_LEN (CHUNK_LEN),
    .NUM_CH    (NUM_CH)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .restart   (restart),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .sel_err   (sel_err),
    .chunk_ofs (chunk_ofs),
    .chunk_idx (chunk_idx)
);

// File: tb/ilv_stream_select_tb_top.sv
module ilv_stream_select_tb_top;

    localparam int CHUNK_LEN = 288;
    localparam int NUM_CH    = 3;
    localparam int SEL_W     = 4;
    localparam int DATA_W    = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              restart = 1'b0;
    logic [SEL_W-1:0]  chan_sel = '0;
    logic              in_valid = 1'b0;
    logic [DATA_W-1:0] in_data = '0;
    logic              in_ready;
    logic              out_valid;
    logic [DATA_W-1:0] out_data;
    logic              out_ready = 1'b0;
    logic              sel_err;

    int n_chk  = 0;
    int n_fail = 0;

    // Reference state
    int m_k   = 0;
    int m_ch  = 1;
    bit m_err = 0;

    always #2ns clk = ~clk;

    ilv_stream_select #(
        .CHUNK_LEN (CHUNK_LEN),
        .NUM_CH    (NUM_CH),
        .SEL_W     (SEL_W),
        .DATA_W    (DATA_W)
    ) dut_i (
        .clk       (clk),
        .rst       (rst),
        .restart   (restart),
        .chan_sel  (chan_sel),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_ready (out_ready),
        .sel_err   (sel_err)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h (k=%0d ch=%0d)", tag, act, exp, m_k, m_ch);
        end
    endtask

    function automatic bit model_owned(input int k, input int ch, input bit err);
        return !err && (((k / CHUNK_LEN) % NUM_CH) == (ch - 1));
    endfunction

    // One ordinary cycle; chan_sel is noise here (R6)
    task automatic step(input logic v, input logic ordy, input logic [SEL_W-1:0] noise);
        bit own;
        logic exp_ir;
        @(negedge clk);
        restart   = 1'b0;
        in_valid  = v;
        out_ready = ordy;
        in_data   = DATA_W'($urandom);
        chan_sel  = noise;
        #1ns;
        own    = model_owned(m_k, m_ch, m_err);
        exp_ir = own ? ordy : 1'b1;
        if (m_k >= NUM_CH * CHUNK_LEN) begin
            // R8: past the wrap the pattern restarts from chunk 0
            check("R8 out_valid after wrap", 32'(out_valid), 32'(v && own));
        end else begin
            check("R2 out_valid by ownership", 32'(out_valid), 32'(v && own));
        end
        if (own)
            check("R4 in_ready follows out_ready", 32'(in_ready), 32'(exp_ir));
        else
            check("R3 in_ready while dropping", 32'(in_ready), 32'(exp_ir));
        if (v && own)
            check("R4 out_data", 32'(out_data), 32'(in_data));
        check("R7 sel_err", 32'(sel_err), 32'(m_err));
        // R9: count moves only on an accepted byte
        if (v && exp_ir) m_k++;
    endtask

    task automatic do_restart(input logic [SEL_W-1:0] sel);
        @(negedge clk);
        restart   = 1'b1;
        chan_sel  = sel;
        in_valid  = 1'b1;
        out_ready = 1'b1;
        #1ns;
        check("R5 in_ready during restart", 32'(in_ready), 32'd0);
        check("R5 out_valid during restart", 32'(out_valid), 32'd0);
        m_k   = 0;
        m_ch  = int'(sel);
        m_err = (sel == 0) || (int'(sel) > NUM_CH);
    endtask

    task automatic run_random(input int cycles, input int vld_pct, input int rdy_pct);
        for (int i = 0; i < cycles; i++) begin
            step(($urandom % 100) < vld_pct, ($urandom % 100) < rdy_pct, SEL_W'($urandom));
        end
    endtask

    initial begin
        #(4ns * 190000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h1F2E3D4C));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1ns;
        // R1: reset state
        check("R1 sel_err after reset", 32'(sel_err), 32'd0);
        check("R1 out_valid idle after reset", 32'(out_valid), 32'd0);
        m_k = 0; m_ch = 1; m_err = 0;
        // R1: first byte is chunk 0, owned by channel 1
        step(1'b1, 1'b1, SEL_W'(0));
        check("R1 count started at zero", 32'(m_k), 32'd1);

        // Channel 1, heavy back-pressure
        run_random(2500, 80, 40);
        // Channel 2, free flowing
        do_restart(SEL_W'(2));
        run_random(2500, 90, 90);
        // Channel 3 (last image), mixed
        do_restart(SEL_W'(3));
        run_random(3000, 70, 60);
        // Long owned stall: count must not move
        do_restart(SEL_W'(1));
        for (int i = 0; i < 20; i++) step(1'b1, 1'b0, SEL_W'($urandom));
        run_random(600, 100, 100);
        // Invalid selects (R7)
        do_restart(SEL_W'(0));
        run_random(700, 80, 30);
        do_restart(SEL_W'(NUM_CH + 1));
        run_random(700, 80, 30);
        // Back to a valid select clears the error
        do_restart(SEL_W'(2));
        run_random(2000, 75, 75);
        // Restart mid-chunk
        do_restart(SEL_W'(1));
        run_random(150, 100, 100);
        do_restart(SEL_W'(1));
        run_random(1200, 85, 70);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule